// File: doc/BRIEF.md
# Per-Queue Interrupt Condition Controller

This block turns queue status flags into interrupt requests for 64 queues. The queues are split into a lower half and an upper half of 32 queues each. Every lower queue has a 3-bit source field. The field picks one of the queue's four status flags and can invert it. Every upper queue always watches its own not-empty flag. A queue's pending bit is set when its condition goes from false to true. Pending bits stay set until software clears them by writing ones, or until the queue's enable bit is turned off. Each half ORs its enabled pending bits into its own interrupt line.

Software uses a flat register port with a single-cycle write and a combinational read. Through it, software programs the source fields, sets the enables, acknowledges pending bits and reads the highest-numbered enabled pending queue of each half. The service routine reads that index register, handles that queue and acknowledges it. It repeats this until the valid flag drops, so higher-numbered queues are always served first. The queue status flags are generated elsewhere and arrive here as inputs.

Top module: `qirq_ctrl`

## Requirements
- R1: After reset every source field, enable bit and pending bit is zero. Every register reads zero and both interrupt lines are low.
- R2: Addresses 0 to 3 hold the source fields. Lower queue i lives at address i/8, in bits 4*(i%8)+2 down to 4*(i%8). Bit 4*(i%8)+3 ignores writes and reads zero.
- R3: The condition of lower queue i is lo_flags[4*i+s], where s is bits 1:0 of its source field. When bit 2 of the field is 1, that flag is inverted.
- R4: The condition of upper queue j is hi_nonempty[j]. The source fields do not affect it.
- R5: A pending bit is set at the clock edge where the queue's condition is true and was false at the previous edge. This happens whether or not the queue is enabled. A condition that stays true does not set the bit again after it has been cleared.
- R6: Writing to address 6 (lower half) or address 7 (upper half) clears the pending bits where the written data has ones. Zero bits leave pending bits unchanged. If a bit is set and cleared in the same cycle, setting wins.
- R7: Addresses 4 (lower half) and 5 (upper half) are the enable registers. A write that changes an enable bit from 1 to 0 also clears that queue's pending bit.
- R8: irq_lo is high exactly when some lower queue is both pending and enabled. irq_hi is the same for the upper half. Both lines change in the cycle after the state change.
- R9: Address 8 (lower half) and address 9 (upper half) are read-only. Bit 31 is set when an enabled pending queue exists in that half. Bits 4:0 then give the highest-numbered such queue, and all other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_flags | input | 128 | Four status flags per lower queue; queue i uses bits 4*i+3 down to 4*i |
| hi_nonempty | input | 32 | Not-empty flag of each upper queue |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data of reg_addr |
| irq_lo | output | 1 | Interrupt line of the lower half |
| irq_hi | output | 1 | Interrupt line of the upper half |

## Verification
The hardest case to reach is a pending bit that is set and cleared in the same cycle. A condition has to rise at exactly the edge where a write-one-to-clear or a disabling write takes effect. The bench sets this up by first dropping the flag for one cycle. It then raises the flag and issues the acknowledge write in the same cycle. A further hard case is an edge caused by reprogramming a source field rather than by a flag change. The bench reaches it by writing a source value that selects, or inverts onto, a flag that is already high. Long random runs of flag changes and register writes are compared every cycle against a behavioural model.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
    localparam int NQH   = 32;
    localparam int NFLAG = 4;
    localparam int SRCW  = 3;
    localparam int NIB   = 4;
    localparam int QPR   = 8;
    localparam int NSRCR = NQH / QPR;
    localparam int DW    = 32;
    localparam int AW    = 4;
    localparam int IDXW  = $clog2(NQH);
    localparam int SELW  = $clog2(NFLAG);

    localparam logic [AW-1:0] A_EN_LO   = AW'(4);
    localparam logic [AW-1:0] A_EN_HI   = AW'(5);
    localparam logic [AW-1:0] A_PEND_LO = AW'(6);
    localparam logic [AW-1:0] A_PEND_HI = AW'(7);
    localparam logic [AW-1:0] A_TOP_LO  = AW'(8);
    localparam logic [AW-1:0] A_TOP_HI  = AW'(9);
endpackage

// File: rtl/qirq_cond_lo.sv
module qirq_cond_lo #(
    parameter int NQ = 32,
    parameter int FL = 4,
    parameter int SW = 3
) (
    input  logic [NQ*FL-1:0] flags,
    input  logic [NQ*SW-1:0] src,
    output logic [NQ-1:0]    cond
);
    localparam int SLW = $clog2(FL);

    for (genvar q = 0; q < NQ; q++) begin : g_q
        logic [FL-1:0]  fq;
        logic [SLW-1:0] sel;
        logic           inv;
        assign fq      = flags[q*FL +: FL];
        assign sel     = src[q*SW +: SLW];
        assign inv     = src[q*SW + SW - 1];
        assign cond[q] = fq[sel] ^ inv;
    end
endmodule

// File: rtl/qirq_prio.sv
module qirq_prio #(
    parameter int N = 32
) (
    input  logic [N-1:0]         req,
    output logic [$clog2(N)-1:0] idx,
    output logic                 vld
);
    localparam int IW = $clog2(N);

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) idx = IW'(i);
        end
        vld = |req;
    end
endmodule

// File: rtl/qirq_half.sv
module qirq_half #(
    parameter int N = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         cond,
    input  logic                 en_we,
    input  logic                 pend_we,
    input  logic [N-1:0]         wdata,
    output logic [N-1:0]         en,
    output logic [N-1:0]         pend,
    output logic [N-1:0]         rise,
    output logic                 irq,
    output logic [$clog2(N)-1:0] top_idx,
    output logic                 top_vld
);
    logic [N-1:0] prev_q;
    logic [N-1:0] clr;

    assign rise = cond & ~prev_q;
    assign clr  = (pend_we ? wdata : '0) | (en_we ? (en & ~wdata) : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            en     <= '0;
            pend   <= '0;
        end else begin
            prev_q <= cond;
            pend   <= (pend & ~clr) | rise;
            if (en_we) en <= wdata;
        end
    end

    qirq_prio #(.N(N)) u_prio (
        .req (pend & en),
        .idx (top_idx),
        .vld (top_vld)
    );

    assign irq = |(pend & en);
endmodule

// File: rtl/qirq_ctrl.sv
module qirq_ctrl
    import qirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NQH*NFLAG-1:0] lo_flags,
    input  logic [NQH-1:0]       hi_nonempty,
    input  logic                 reg_we,
    input  logic [AW-1:0]        reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    output logic                 irq_lo,
    output logic                 irq_hi
);
    logic [NQH*SRCW-1:0] src_q;
    logic [NQH-1:0]      cond_lo;
    logic [NQH-1:0]      en_lo, en_hi, pend_lo, pend_hi, rise_lo, rise_hi;
    logic [IDXW-1:0]     idx_lo, idx_hi;
    logic                vld_lo, vld_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
        end else if (reg_we) begin
            for (int r = 0; r < NSRCR; r++) begin
                if (reg_addr == AW'(r)) begin
                    for (int k = 0; k < QPR; k++) begin
                        src_q[(r*QPR+k)*SRCW +: SRCW] <= reg_wdata[k*NIB +: SRCW];
                    end
                end
            end
        end
    end

    qirq_cond_lo #(.NQ(NQH), .FL(NFLAG), .SW(SRCW)) u_cond (
        .flags (lo_flags),
        .src   (src_q),
        .cond  (cond_lo)
    );

    qirq_half #(.N(NQH)) u_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond    (cond_lo),
        .en_we   (reg_we && reg_addr == A_EN_LO),
        .pend_we (reg_we && reg_addr == A_PEND_LO),
        .wdata   (reg_wdata[NQH-1:0]),
        .en      (en_lo),
        .pend    (pend_lo),
        .rise    (rise_lo),
        .irq     (irq_lo),
        .top_idx (idx_lo),
        .top_vld (vld_lo)
    );

    qirq_half #(.N(NQH)) u_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond    (hi_nonempty),
        .en_we   (reg_we && reg_addr == A_EN_HI),
        .pend_we (reg_we && reg_addr == A_PEND_HI),
        .wdata   (reg_wdata[NQH-1:0]),
        .en      (en_hi),
        .pend    (pend_hi),
        .rise    (rise_hi),
        .irq     (irq_hi),
        .top_idx (idx_hi),
        .top_vld (vld_hi)
    );

    always_comb begin
        reg_rdata = '0;
        for (int r = 0; r < NSRCR; r++) begin
            if (reg_addr == AW'(r)) begin
                for (int k = 0; k < QPR; k++) begin
                    reg_rdata[k*NIB +: SRCW] = src_q[(r*QPR+k)*SRCW +: SRCW];
                end
            end
        end
        case (reg_addr)
            A_EN_LO:   reg_rdata = DW'(en_lo);
            A_EN_HI:   reg_rdata = DW'(en_hi);
            A_PEND_LO: reg_rdata = DW'(pend_lo);
            A_PEND_HI: reg_rdata = DW'(pend_hi);
            A_TOP_LO:  reg_rdata = {vld_lo, {(DW-1-IDXW){1'b0}}, idx_lo};
            A_TOP_HI:  reg_rdata = {vld_hi, {(DW-1-IDXW){1'b0}}, idx_hi};
            default:   ;
        endcase
    end
endmodule

// File: rtl/qirq_chk.sv
module qirq_chk
    import qirq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            reg_we,
    input logic [AW-1:0]   reg_addr,
    input logic [DW-1:0]   reg_wdata,
    input logic [NQH-1:0]  pend_lo,
    input logic [NQH-1:0]  pend_hi,
    input logic [NQH-1:0]  en_lo,
    input logic [NQH-1:0]  en_hi,
    input logic [NQH-1:0]  rise_lo,
    input logic [NQH-1:0]  rise_hi,
    input logic            irq_lo,
    input logic            irq_hi,
    input logic            vld_lo,
    input logic            vld_hi
);
    assert_rise_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_lo & $past(rise_lo)) == $past(rise_lo)) &&
                 ((pend_hi & $past(rise_hi)) == $past(rise_hi)));

    assert_no_spurious_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_lo & ~$past(pend_lo) & ~$past(rise_lo)) == '0) &&
                 ((pend_hi & ~$past(pend_hi) & ~$past(rise_hi)) == '0));

    assert_w1c_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_PEND_LO) |=>
            ((pend_lo & $past(reg_wdata[NQH-1:0]) & ~$past(rise_lo)) == '0));

    assert_w1c_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_PEND_HI) |=>
            ((pend_hi & $past(reg_wdata[NQH-1:0]) & ~$past(rise_hi)) == '0));

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_EN_LO) |=>
            ((pend_lo & $past(en_lo & ~reg_wdata[NQH-1:0]) & ~$past(rise_lo)) == '0));

    assert_disable_clears_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_EN_HI) |=>
            ((pend_hi & $past(en_hi & ~reg_wdata[NQH-1:0]) & ~$past(rise_hi)) == '0));

    assert_irq_matches_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo == vld_lo) && (irq_hi == vld_hi));
endmodule

bind qirq_ctrl qirq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pend_lo   (pend_lo),
    .pend_hi   (pend_hi),
    .en_lo     (en_lo),
    .en_hi     (en_hi),
    .rise_lo   (rise_lo),
    .rise_hi   (rise_hi),
    .irq_lo    (irq_lo),
    .irq_hi    (irq_hi),
    .vld_lo    (vld_lo),
    .vld_hi    (vld_hi)
);

// File: tb/tb_qirq_ctrl.sv
module tb_qirq_ctrl;
    localparam int CLK_P = 10;

    logic         clk;
    logic         rst_n;
    logic [127:0] lo_flags;
    logic [31:0]  hi_nonempty;
    logic         reg_we;
    logic [3:0]   reg_addr;
    logic [31:0]  reg_wdata;
    logic [31:0]  reg_rdata;
    logic         irq_lo, irq_hi;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    qirq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .lo_flags(lo_flags), .hi_nonempty(hi_nonempty),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    initial clk = 0;
    always #(CLK_P/2) clk = ~clk;

    // behavioural model state
    logic [2:0]  m_src [32];
    logic [31:0] m_en   [2];
    logic [31:0] m_pend [2];
    logic [31:0] m_prev [2];

    function automatic logic m_cond(int q);
        if (q < 32) return lo_flags[4*q + int'(m_src[q][1:0])] ^ m_src[q][2];
        return hi_nonempty[q-32];
    endfunction

    function automatic logic [31:0] m_read(logic [3:0] a);
        logic [31:0] v;
        logic [31:0] act;
        v = 0;
        if (a < 4) begin
            for (int k = 0; k < 8; k++) v[4*k +: 3] = m_src[int'(a)*8 + k];
        end else if (a == 4 || a == 5) v = m_en[a-4];
        else if (a == 6 || a == 7) v = m_pend[a-6];
        else if (a == 8 || a == 9) begin
            act = m_pend[a-8] & m_en[a-8];
            for (int i = 0; i < 32; i++) if (act[i]) v = 32'h8000_0000 | i;
        end
        return v;
    endfunction

    function automatic string tag_of(logic [3:0] a);
        if (a < 4) return "R2";
        if (a < 6) return "R7";
        if (a < 8) return "R6";
        return "R9";
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [31:0] c [2];
        logic [31:0] clr;
        if (!rst_n) begin
            for (int q = 0; q < 32; q++) m_src[q] = 0;
            for (int h = 0; h < 2; h++) begin
                m_en[h] = 0; m_pend[h] = 0; m_prev[h] = 0;
            end
            return;
        end
        for (int q = 0; q < 64; q++) c[q/32][q%32] = m_cond(q);
        for (int h = 0; h < 2; h++) begin
            clr = 0;
            if (reg_we && reg_addr == 4'(6+h)) clr |= reg_wdata;
            if (reg_we && reg_addr == 4'(4+h)) clr |= m_en[h] & ~reg_wdata;
            m_pend[h] = (m_pend[h] & ~clr) | (c[h] & ~m_prev[h]);
            if (reg_we && reg_addr == 4'(4+h)) m_en[h] = reg_wdata;
            m_prev[h] = c[h];
        end
        if (reg_we && reg_addr < 4)
            for (int k = 0; k < 8; k++) m_src[int'(reg_addr)*8 + k] = reg_wdata[4*k +: 3];
    endtask

    task automatic step();
        logic [31:0] e;
        @(posedge clk);
        model_edge();
        #1;
        chk(irq_lo === |(m_pend[0] & m_en[0]), "R8", 32'(irq_lo), 32'(|(m_pend[0] & m_en[0])));
        chk(irq_hi === |(m_pend[1] & m_en[1]), "R8", 32'(irq_hi), 32'(|(m_pend[1] & m_en[1])));
        e = m_read(reg_addr);
        chk(reg_rdata === e, tag_of(reg_addr), reg_rdata, e);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 0;
    endtask

    task automatic rd_chk(logic [3:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; lo_flags = 0; hi_nonempty = 0;
        reg_we = 0; reg_addr = 0; reg_wdata = 0;
        repeat (3) step();
        // R1: everything zero under reset
        for (int a = 0; a < 10; a++) rd_chk(4'(a), 0, "R1");
        chk(irq_lo === 0 && irq_hi === 0, "R1", 32'({irq_lo, irq_hi}), 0);
        #2 rst_n = 1;
        step();

        // R2: field layout, reserved bits
        wr(0, 32'hFFFF_FFFF);
        rd_chk(0, 32'h7777_7777, "R2");
        wr(1, 32'h0123_4567);
        rd_chk(1, 32'h0123_4567, "R2");
        wr(0, 0); wr(1, 0);
        wr(6, 32'hFFFF_FFFF);
        step();
        rd_chk(6, 0, "R6");

        // R3: selection and inversion
        lo_flags[4*5+1] = 1;
        step(); step();
        rd_chk(6, 0, "R3");
        wr(0, 32'h0010_0000);
        step();
        rd_chk(6, 32'h20, "R3");
        wr(0, 32'h0410_0000);
        step();
        rd_chk(6, 32'h60, "R3");

        // R5: steady level does not re-set; new edge does
        wr(6, 32'h60);
        repeat (3) step();
        rd_chk(6, 0, "R5");
        lo_flags[21] = 0; step();
        lo_flags[21] = 1; step();
        rd_chk(6, 32'h20, "R5");

        // R8 / R9
        chk(irq_lo === 0, "R8", 32'(irq_lo), 0);
        wr(4, 32'h20);
        chk(irq_lo === 1, "R8", 32'(irq_lo), 1);
        rd_chk(8, 32'h8000_0005, "R9");
        lo_flags[24] = 1; step();
        lo_flags[24] = 0; step();
        wr(4, 32'h60);
        rd_chk(8, 32'h8000_0006, "R9");

        // R6: zero bits leave others alone
        wr(6, 32'h20);
        rd_chk(6, 32'h40, "R6");

        // R7: disabling clears pending
        wr(4, 32'h20);
        rd_chk(6, 0, "R7");
        rd_chk(4, 32'h20, "R7");
        chk(irq_lo === 0, "R8", 32'(irq_lo), 0);

        // R6: set wins over clear in the same cycle
        lo_flags[21] = 0; step();
        lo_flags[21] = 1;
        wr(6, 32'h20);
        rd_chk(6, 32'h20, "R6");

        // R4: upper half follows not-empty only
        hi_nonempty[31] = 1; step();
        rd_chk(7, 32'h8000_0000, "R4");
        wr(5, 32'h8000_0001);
        chk(irq_hi === 1, "R8", 32'(irq_hi), 1);
        rd_chk(9, 32'h8000_001F, "R9");
        hi_nonempty[0] = 1; step();
        rd_chk(9, 32'h8000_001F, "R9");
        wr(7, 32'h8000_0000);
        rd_chk(9, 32'h8000_0000, "R9");

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 3) == 0) lo_flags[$urandom_range(0, 127)] ^= 1'b1;
            if ($urandom_range(0, 5) == 0) hi_nonempty[$urandom_range(0, 31)] ^= 1'b1;
            reg_we    = ($urandom_range(0, 3) == 0);
            reg_addr  = 4'($urandom_range(0, 10));
            reg_wdata = $urandom();
            step();
        end
        reg_we = 0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule